// File: doc/BRIEF.md
# Timer Time Base with Repetition Gating

This block turns a stream of count-enable ticks into a periodic update-event pulse. Ticks pass through three cascaded dividers. A prescaler passes one tick in every PSC+1. A main counter is bounded by an auto-reload limit ARR. A repetition counter lets only one in every RCR+1 counter wrap-arounds become an update. The main counter runs in one of three ways. It can count up and wrap to zero, count down and reload from the limit, or count center-aligned, rising to the limit and then falling back to zero. In center-aligned mode, both turning points count as wrap-arounds.

Two inputs force an update at once and restart the whole chain: a software request and a request from a slave-mode controller. The update pulse lasts one clock cycle. It can be fed to the tick input of a second instance, so that several time bases can be chained as prescalers for one another. Clock-source selection, input filtering, capture/compare channels and any bus access sit outside this block. Register values arrive as plain input ports.

Top module: `tbase_top`

## Requirements
- R1: With tick_en held high in edge-aligned mode and the values held constant after a forced update, upd_pulse is high once every (PSC+1)*(ARR+1)*(RCR+1) cycles.
- R2: The counter takes one step on every tick_en cycle in which the prescaler count is equal to or greater than psc_val. On other tick_en cycles the prescaler count increments. In a cycle with tick_en low and no forced update, count and all other state hold.
- R3: In edge-aligned mode (mode_sel = 0) with dir_down = 0, a step increments count. A step taken while count >= arr_val sets count to 0 and is a wrap-around.
- R4: In edge-aligned mode with dir_down = 1, a step decrements count. A step taken at count = 0 loads arr_val and is a wrap-around. In this mode, dir_dn equals dir_down.
- R5: Any non-zero mode_sel selects center-aligned counting. The counter rises, and a step at count >= arr_val turns it down to arr_val-1. While falling, a step at count 0 turns it up to 1. Both turns are wrap-arounds. dir_dn is 1 while falling.
- R6: Each wrap-around decrements the repetition count. An update happens only when a wrap-around finds the repetition count at 0, and the repetition count then reloads rcr_val. After reset the repetition count is 0.
- R7: When sw_upd or slv_upd is high at an edge, the following actions take priority over any tick. An update happens. The prescaler clears. count becomes arr_val in edge-aligned down mode and 0 in all other modes. The repetition count loads rcr_val. A center-aligned counter restarts rising.
- R8: With arr_val = 0, count stays 0 and every step is a wrap-around.
- R9: During and right after reset, count is 0 and upd_pulse is 0.
- R10: upd_pulse is registered. It is high for exactly the one cycle after the clock edge at which an update happens, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-enable tick |
| psc_val | input | 16 | Prescaler divide value minus one |
| arr_val | input | 16 | Auto-reload limit |
| rcr_val | input | 16 | Repetition value |
| mode_sel | input | 2 | 0 edge-aligned, non-zero center-aligned |
| dir_down | input | 1 | Edge-aligned direction, 1 = down |
| sw_upd | input | 1 | Software forced update |
| slv_upd | input | 1 | Slave-mode forced update |
| count | output | 16 | Current counter value |
| upd_pulse | output | 1 | One-cycle update event |
| dir_dn | output | 1 | Current counting direction, 1 = down |

## Verification
A wrong prescaler or counter value first appears on count, in the cycle after the step that goes wrong. The bench compares count against its own model on every cycle, so this kind of error is caught within one cycle. A corrupted repetition count is invisible on count. It only shows as a missing or extra upd_pulse at the next wrap-around, which can be up to (PSC+1)*(ARR+1) ticks later. To keep that delay short, the random phase uses small limits and the directed phases measure the spacing between pulses. Center-aligned direction errors are seen on dir_dn in the same cycle.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
    typedef enum logic {
        CDIR_UP   = 1'b0,
        CDIR_DOWN = 1'b1
    } cdir_e;
endpackage

// File: rtl/tbase_presc.sv
module tbase_presc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clear,
    input  logic [W-1:0] psc_val,
    output logic         step
);
    logic [W-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q;
        step  = 1'b0;
        if (clear) begin
            div_d = '0;
        end else if (tick) begin
            if (div_q >= psc_val) begin
                div_d = '0;
                step  = 1'b1;
            end else begin
                div_d = div_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R2: a passed tick restarts the division
    a_r2_step_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (div_q == '0));
    // R7: forced clear empties the prescaler
    a_r7_clear_presc: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (div_q == '0));
endmodule

// File: rtl/tbase_cnt.sv
module tbase_cnt
    import tbase_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         force_upd,
    input  logic         center,
    input  logic         dir_down,
    input  logic [W-1:0] arr_val,
    output logic [W-1:0] count,
    output logic         dir_dn,
    output logic         wrap
);
    typedef struct packed {
        logic [W-1:0] cnt;
        cdir_e        cdir;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (force_upd) begin
            st_d.cnt  = (!center && dir_down) ? arr_val : '0;
            st_d.cdir = CDIR_UP;
        end else if (step) begin
            if (!center) begin
                if (!dir_down) begin
                    if (st_q.cnt >= arr_val) begin
                        st_d.cnt = '0;
                        wrap     = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end else begin
                    if (st_q.cnt == '0) begin
                        st_d.cnt = arr_val;
                        wrap     = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
            end else if (st_q.cdir == CDIR_UP) begin
                if (st_q.cnt >= arr_val) begin
                    wrap = 1'b1;
                    if (arr_val == '0) begin
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt  = arr_val - 1'b1;
                        st_d.cdir = CDIR_DOWN;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                if (st_q.cnt == '0) begin
                    wrap      = 1'b1;
                    st_d.cdir = CDIR_UP;
                    st_d.cnt  = (arr_val == '0) ? '0 : {{(W-1){1'b0}}, 1'b1};
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
        if (!center) st_d.cdir = CDIR_UP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.cdir <= CDIR_UP;
        end else begin
            st_q <= st_d;
        end
    end

    assign count  = st_q.cnt;
    assign dir_dn = center ? (st_q.cdir == CDIR_DOWN) : dir_down;

    // R2: no step and no force keeps the count
    a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !force_upd) |=> $stable(count));
    // R3: up-counting wraps to zero at the limit
    a_r3_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !force_upd && !center && !dir_down && count >= arr_val) |=> (count == '0));
    // R4: down-counting reloads the limit at zero
    a_r4_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !force_upd && !center && dir_down && count == '0) |=> (count == $past(arr_val)));
    // R5: center-aligned counter turns down at the limit
    a_r5_center_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !force_upd && center && !dir_dn && arr_val != '0 && count >= arr_val)
        |=> (!center || dir_dn));
    // R8: zero limit holds the counter at zero
    a_r8_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !force_upd && arr_val == '0 && count == '0) |=> (count == '0));
endmodule

// File: rtl/tbase_rep.sv
module tbase_rep #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wrap,
    input  logic         force_upd,
    input  logic [W-1:0] rcr_val,
    output logic         upd
);
    typedef struct packed {
        logic [W-1:0] rep;
        logic         upd;
    } rep_st_t;

    rep_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (force_upd) begin
            st_d.rep = rcr_val;
            st_d.upd = 1'b1;
        end else if (wrap) begin
            if (st_q.rep == '0) begin
                st_d.rep = rcr_val;
                st_d.upd = 1'b1;
            end else begin
                st_d.rep = st_q.rep - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rep <= '0;
            st_q.upd <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign upd = st_q.upd;

    // R7: a forced request always yields an update
    a_r7_force_upd: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |=> upd);
    // R6: a wrap with repetitions pending yields no update
    a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !force_upd && st_q.rep != '0) |=> !upd);
    // R10: no cause, no pulse
    a_r10_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !force_upd) |=> !upd);
endmodule

// File: rtl/tbase_top.sv
module tbase_top #(
    parameter int W  = 16,
    parameter int MW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic [W-1:0]  psc_val,
    input  logic [W-1:0]  arr_val,
    input  logic [W-1:0]  rcr_val,
    input  logic [MW-1:0] mode_sel,
    input  logic          dir_down,
    input  logic          sw_upd,
    input  logic          slv_upd,
    output logic [W-1:0]  count,
    output logic          upd_pulse,
    output logic          dir_dn
);
    logic force_upd;
    logic center;
    logic step;
    logic wrap;

    assign force_upd = sw_upd | slv_upd;
    assign center    = |mode_sel;

    tbase_presc #(.W(W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .clear   (force_upd),
        .psc_val (psc_val),
        .step    (step)
    );

    tbase_cnt #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .force_upd (force_upd),
        .center    (center),
        .dir_down  (dir_down),
        .arr_val   (arr_val),
        .count     (count),
        .dir_dn    (dir_dn),
        .wrap      (wrap)
    );

    tbase_rep #(.W(W)) u_rep (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap      (wrap),
        .force_upd (force_upd),
        .rcr_val   (rcr_val),
        .upd       (upd_pulse)
    );

    // R9: reset leaves the outputs idle
    a_r9_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !upd_pulse));
endmodule

// File: tb/tbase_top_test.sv
module tbase_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [15:0] psc_val = '0, arr_val = '0, rcr_val = '0;
    logic [1:0]  mode_sel = '0;
    logic        dir_down = 1'b0, sw_upd = 1'b0, slv_upd = 1'b0;
    logic [15:0] count;
    logic        upd_pulse, dir_dn;

    int checks = 0, fails = 0;
    int cyc_n = 0, last_up = -1, gap_exp = 0, gap_skip = 0;
    string gap_req = "R1";

    logic [15:0] m_psc = '0, m_cnt = '0, m_rep = '0;
    logic        m_cdir = 1'b0, m_upd = 1'b0;

    always #2 clk = ~clk;

    tbase_top uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psc_val(psc_val),
        .arr_val(arr_val), .rcr_val(rcr_val), .mode_sel(mode_sel),
        .dir_down(dir_down), .sw_upd(sw_upd), .slv_upd(slv_upd),
        .count(count), .upd_pulse(upd_pulse), .dir_dn(dir_dn)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc_n);
        end
    endtask

    // one clock cycle: model the next state from the requirements, then compare
    task automatic cyc();
        logic [15:0] n_psc, n_cnt, n_rep;
        logic n_cdir, n_upd, stp, ev, ctr;
        logic exp_dir;
        n_psc = m_psc; n_cnt = m_cnt; n_rep = m_rep; n_cdir = m_cdir;
        n_upd = 1'b0; stp = 1'b0; ev = 1'b0; ctr = (mode_sel != 2'd0);
        if (sw_upd || slv_upd) begin
            n_psc = '0; n_rep = rcr_val; n_upd = 1'b1; n_cdir = 1'b0;
            n_cnt = (!ctr && dir_down) ? arr_val : 16'd0;
        end else begin
            if (tick_en) begin
                if (m_psc >= psc_val) begin n_psc = '0; stp = 1'b1; end
                else n_psc = m_psc + 16'd1;
            end
            if (stp) begin
                if (!ctr && !dir_down) begin
                    if (m_cnt >= arr_val) begin n_cnt = 0; ev = 1; end else n_cnt = m_cnt + 16'd1;
                end else if (!ctr) begin
                    if (m_cnt == 0) begin n_cnt = arr_val; ev = 1; end else n_cnt = m_cnt - 16'd1;
                end else if (!m_cdir) begin
                    if (m_cnt >= arr_val) begin
                        ev = 1;
                        if (arr_val == 0) n_cnt = 0;
                        else begin n_cnt = arr_val - 16'd1; n_cdir = 1'b1; end
                    end else n_cnt = m_cnt + 16'd1;
                end else begin
                    if (m_cnt == 0) begin
                        ev = 1; n_cdir = 1'b0; n_cnt = (arr_val == 0) ? 16'd0 : 16'd1;
                    end else n_cnt = m_cnt - 16'd1;
                end
            end
            if (ev) begin
                if (m_rep == 0) begin n_rep = rcr_val; n_upd = 1'b1; end
                else n_rep = m_rep - 16'd1;
            end
        end
        if (!ctr) n_cdir = 1'b0;
        @(posedge clk);
        #1;
        cyc_n++;
        m_psc = n_psc; m_cnt = n_cnt; m_rep = n_rep; m_cdir = n_cdir; m_upd = n_upd;
        exp_dir = (mode_sel != 2'd0) ? m_cdir : dir_down;
        chk(count == m_cnt, "R2/R3/R4/R5 count", count, m_cnt);
        chk(upd_pulse == m_upd, "R6/R10 upd_pulse", upd_pulse, m_upd);
        chk(dir_dn == exp_dir, "R5 dir_dn", dir_dn, exp_dir);
        if (upd_pulse && gap_exp > 0) begin
            if (last_up >= 0) begin
                if (gap_skip > 0) gap_skip--;
                else chk(cyc_n - last_up == gap_exp, gap_req, cyc_n - last_up, gap_exp);
            end
            last_up = cyc_n;
        end
        @(negedge clk);
    endtask

    task automatic forced(input bit slave);
        if (slave) slv_upd = 1'b1; else sw_upd = 1'b1;
        cyc();
        chk(upd_pulse == 1'b1, "R7 forced pulse", upd_pulse, 1);
        sw_upd = 1'b0; slv_upd = 1'b0;
    endtask

    task automatic setup(input int p, input int a, input int r, input int md,
                         input bit dn, input int gap, input int skip, input string req);
        psc_val = p[15:0]; arr_val = a[15:0]; rcr_val = r[15:0];
        mode_sel = md[1:0]; dir_down = dn;
        gap_exp = gap; gap_skip = skip; gap_req = req; last_up = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc_n, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] hold;
        void'($urandom(32'd20240611));
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(count == 16'd0, "R9 count in reset", count, 0);
        chk(upd_pulse == 1'b0, "R9 upd in reset", upd_pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 and R3: edge up, (2+1)*(3+1)*(1+1) = 24
        setup(2, 3, 1, 0, 1'b0, 24, 0, "R1 up gap");
        forced(1'b0);
        tick_en = 1'b1;
        repeat (100) cyc();

        // R4: edge down, same spacing
        setup(2, 3, 1, 0, 1'b1, 24, 0, "R4 down gap");
        forced(1'b0);
        chk(count == 16'd3, "R4/R7 count loads limit", count, 3);
        repeat (100) cyc();

        // R5: center-aligned, event at each turn, every 3 steps after the first
        setup(0, 3, 0, 2, 1'b0, 3, 1, "R5 center gap");
        forced(1'b1);
        repeat (40) cyc();

        // R8: zero limit, prescaler 2 -> update every 2 cycles
        setup(1, 0, 0, 0, 1'b0, 2, 0, "R8 zero limit gap");
        forced(1'b0);
        repeat (20) begin
            cyc();
            chk(count == 16'd0, "R8 count holds 0", count, 0);
        end

        // R6: repetition 2 with limit 1 -> 6 cycles between updates
        setup(0, 1, 2, 0, 1'b0, 6, 0, "R6 repetition gap");
        forced(1'b0);
        repeat (40) cyc();

        // R2: ticks withheld freeze the counter
        setup(0, 5, 0, 0, 1'b0, 0, 0, "R2");
        repeat (3) cyc();
        hold = count;
        tick_en = 1'b0;
        repeat (10) cyc();
        chk(count == hold, "R2 frozen without ticks", count, hold);
        chk(upd_pulse == 1'b0, "R2 no pulse without ticks", upd_pulse, 0);

        // R7: slave request beats a tick, count restarts at 0
        tick_en = 1'b1;
        forced(1'b1);
        chk(count == 16'd0, "R7 count restart", count, 0);
        cyc();
        chk(upd_pulse == 1'b0, "R10 pulse lasts one cycle", upd_pulse, 0);

        // random phase
        gap_exp = 0;
        for (int i = 0; i < 6000; i++) begin
            if (i % 300 == 0) begin
                psc_val  = 16'($urandom_range(0, 3));
                arr_val  = 16'($urandom_range(0, 7));
                rcr_val  = 16'($urandom_range(0, 3));
                mode_sel = 2'($urandom_range(0, 3));
                dir_down = 1'($urandom_range(0, 1));
            end
            tick_en = ($urandom_range(0, 3) != 0);
            sw_upd  = ($urandom_range(0, 63) == 0);
            slv_upd = ($urandom_range(0, 63) == 0);
            cyc();
        end
        sw_upd = 1'b0; slv_upd = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule